// File: doc/BRIEF.md
# Receive Link Polarity Detector

This block watches the receive side of a 10BASE-T port for evidence that the receive wire pair is crossed. The receive front end signals four kinds of event as single-cycle pulses: a link pulse of normal polarity, a link pulse of inverted polarity, a packet ending whose end-of-packet pulse has normal polarity, and a packet ending whose end-of-packet pulse is inverted. Two separate streak counters track the inverted events. The link-pulse path needs seven in a row. The packet path needs three in a row. When either streak completes, a sticky bad-polarity flag is set.

While the flag is set, the block inverts the received data bits it passes downstream, so decoding continues to work and the cabling fault can wait for a service visit. The flag and both streak counters return to zero only on reset or on the explicit clear input. The thresholds and the data width are parameters.

Top module: `pol_detect`

## Requirements
- R1: After a synchronous reset, pol_bad is 0 and rx_fix equals rx_raw.
- R2: pol_bad becomes 1 in the cycle after the clock edge that samples the seventh inverted link pulse (lnk_rev) with no normal link pulse between them. Six such pulses leave it at 0. Idle cycles between pulses do not break the streak.
- R3: A normal link pulse (lnk_ok) resets the inverted-link-pulse streak to zero. If lnk_ok and lnk_rev are high in the same cycle, the normal pulse wins and the streak becomes zero.
- R4: pol_bad becomes 1 in the cycle after the edge that samples the third inverted packet ending (eop_rev) with no normal packet ending between them. Two such endings leave it at 0.
- R5: A normal packet ending (eop_ok) resets the inverted-packet streak to zero. If eop_ok and eop_rev are high in the same cycle, the normal ending wins.
- R6: The two streaks are independent. Link-pulse events never change the packet streak, and packet events never change the link-pulse streak.
- R7: Once set, pol_bad stays 1 whatever events arrive, until clr or reset.
- R8: clr high at a clock edge clears pol_bad and both streaks at that edge. Any polarity events sampled in the same cycle are ignored.
- R9: rx_fix equals rx_raw with every bit inverted while pol_bad is 1, and equals rx_raw while it is 0. There is no added register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Clears the flag and both streaks |
| lnk_ok | input | 1 | Normal-polarity link pulse seen (one-cycle pulse) |
| lnk_rev | input | 1 | Inverted link pulse seen (one-cycle pulse) |
| eop_ok | input | 1 | Packet ended with normal end-of-packet polarity |
| eop_rev | input | 1 | Packet ended with inverted end-of-packet polarity |
| rx_raw | input | DW | Received data bits before correction |
| pol_bad | output | 1 | Latched bad-polarity flag |
| rx_fix | output | DW | Received data, inverted while pol_bad is set |

## Verification
The bench drives streaks that stop exactly one event short of each threshold, then completes them. A design with an off-by-one count would set the flag too early or never set it. Normal events are placed in the middle of a streak, alone and coincident with an inverted event. A design that let the inverted event win, or that let one path's normal event reset the other path's streak, would raise the flag where the bench expects 0, or miss it where the bench expects 1. A clear is issued in the same cycle as an inverted pulse, and is followed by exactly one threshold-minus-one streak. A design that counted the pulse in the clear cycle would trip early. Normal traffic is sent after the flag is set. A design whose flag was not sticky would drop it, and that shows on both pol_bad and the corrected data.

// File: rtl/pol_pkg.sv
package pol_pkg;

    // One polarity event source: normal and inverted indications
    typedef struct packed {
        logic norm;
        logic inv;
    } pol_evt_t;

    // Trigger paths, index into the streak counter array
    typedef enum int {
        PATH_LINK = 0,
        PATH_PKT  = 1
    } pol_path_e;

    localparam int NPATH = 2;

    // Next streak value: normal wins, inverted counts up and saturates at thr
    function automatic int unsigned streak_next(int unsigned cur,
                                                logic norm, logic inv,
                                                int unsigned thr);
        if (norm)
            return 0;
        else if (inv && cur < thr)
            return cur + 1;
        else
            return cur;
    endfunction

endpackage

// File: rtl/pol_streak_ctr.sv
module pol_streak_ctr
    import pol_pkg::*;
#(
    parameter int THR = 7
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  pol_evt_t evt,
    output logic     trip
);
    localparam int CW = $clog2(THR + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nx;

    always_comb begin
        cnt_nx = CW'(streak_next(int'(cnt_q), evt.norm, evt.inv, THR));
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else
            cnt_q <= cnt_nx;
    end

    // Streak reaches its threshold on this edge
    assign trip = !clr && (cnt_nx == CW'(THR));

endmodule

// File: rtl/pol_flag_latch.sv
module pol_flag_latch
    import pol_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [NPATH-1:0] set_req,
    output logic             bad
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            bad <= 1'b0;
        else if (|set_req)
            bad <= 1'b1;
    end
endmodule

// File: rtl/pol_data_fix.sv
module pol_data_fix #(
    parameter int DW = 1
) (
    input  logic          bad,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    always_comb begin
        dout = din ^ {DW{bad}};
    end
endmodule

// File: rtl/pol_detect.sv
module pol_detect
    import pol_pkg::*;
#(
    parameter int LINK_THR = 7,
    parameter int PKT_THR  = 3,
    parameter int DW       = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          lnk_ok,
    input  logic          lnk_rev,
    input  logic          eop_ok,
    input  logic          eop_rev,
    input  logic [DW-1:0] rx_raw,
    output logic          pol_bad,
    output logic [DW-1:0] rx_fix
);
    pol_evt_t         evt [NPATH];
    logic [NPATH-1:0] trip;

    always_comb begin
        evt[PATH_LINK] = '{norm: lnk_ok, inv: lnk_rev};
        evt[PATH_PKT]  = '{norm: eop_ok, inv: eop_rev};
    end

    for (genvar g = 0; g < NPATH; g++) begin : g_path
        localparam int T = (g == PATH_LINK) ? LINK_THR : PKT_THR;
        pol_streak_ctr #(.THR(T)) u_ctr (
            .clk  (clk),
            .rst  (rst),
            .clr  (clr),
            .evt  (evt[g]),
            .trip (trip[g])
        );
    end

    pol_flag_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .set_req (trip),
        .bad     (pol_bad)
    );

    pol_data_fix #(.DW(DW)) u_fix (
        .bad  (pol_bad),
        .din  (rx_raw),
        .dout (rx_fix)
    );
endmodule

// File: rtl/pol_detect_chk.sv
module pol_detect_chk #(
    parameter int DW = 1
) (
    input logic          clk,
    input logic          rst,
    input logic          clr,
    input logic          lnk_rev,
    input logic          eop_rev,
    input logic [DW-1:0] rx_raw,
    input logic          pol_bad,
    input logic [DW-1:0] rx_fix
);
    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !pol_bad);

    // R2
    set_needs_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (!pol_bad && !lnk_rev && !eop_rev) |=> !pol_bad);

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (pol_bad && !clr) |=> pol_bad);

    // R8
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !pol_bad);

    // R9
    fix_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pol_bad) |-> (rx_fix == ~rx_raw));

    // R9
    pass_when_good_chk: assert property (@(posedge clk) disable iff (rst)
        !pol_bad |-> (rx_fix == rx_raw));
endmodule

bind pol_detect pol_detect_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .lnk_rev (lnk_rev),
    .eop_rev (eop_rev),
    .rx_raw  (rx_raw),
    .pol_bad (pol_bad),
    .rx_fix  (rx_fix)
);

// File: tb/pol_detect_test.sv
module pol_detect_test;
    localparam int LTHR = 7;
    localparam int PTHR = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clr = 1'b0;
    logic lnk_ok = 1'b0, lnk_rev = 1'b0, eop_ok = 1'b0, eop_rev = 1'b0;
    logic [0:0] rx_raw = 1'b0;
    logic pol_bad;
    logic [0:0] rx_fix;

    always #4 clk = ~clk;

    pol_detect #(.LINK_THR(LTHR), .PKT_THR(PTHR), .DW(1)) uut (
        .clk(clk), .rst(rst), .clr(clr),
        .lnk_ok(lnk_ok), .lnk_rev(lnk_rev), .eop_ok(eop_ok), .eop_rev(eop_rev),
        .rx_raw(rx_raw), .pol_bad(pol_bad), .rx_fix(rx_fix)
    );

    typedef struct {
        logic  bad;
        logic  fix;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 0;

    // reference state, built from the requirements
    int   m_l = 0, m_p = 0;
    logic m_f = 1'b0;

    // drive one cycle; push what outputs must show during it; advance model
    task automatic step(input logic ln, input logic li, input logic en,
                        input logic ei, input logic rx, input logic c,
                        input string req);
        exp_t e;
        @(negedge clk);
        lnk_ok = ln; lnk_rev = li; eop_ok = en; eop_rev = ei;
        rx_raw = rx; clr = c;
        e.bad = m_f; e.fix = rx ^ m_f; e.req = req;
        exp_q.push_back(e);
        if (c) begin
            m_l = 0; m_p = 0; m_f = 1'b0;
        end else begin
            if (ln) m_l = 0; else if (li && m_l < LTHR) m_l++;
            if (en) m_p = 0; else if (ei && m_p < PTHR) m_p++;
            if (m_l >= LTHR || m_p >= PTHR) m_f = 1'b1;
        end
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, i[0], 0, req);
    endtask

    task automatic lrev(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            step(0, 1, 0, 0, 1'b1, 0, req);
            step(0, 0, 0, 0, 1'b0, 0, req); // gap must not break the streak
        end
    endtask

    task automatic erev(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            step(0, 0, 0, 1, 1'b0, 0, req);
            step(0, 0, 0, 0, 1'b1, 0, req);
        end
    endtask

    task automatic do_clr(input string req);
        step(0, 0, 0, 0, 1'b1, 1, req);
    endtask

    // monitor: compares every cycle that has a pushed expectation
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_cmp++;
                if (pol_bad !== e.bad) begin
                    n_bad++;
                    $display("FAIL %s pol_bad actual=%b expected=%b", e.req, pol_bad, e.bad);
                end
                n_cmp++;
                if (rx_fix[0] !== e.fix) begin
                    n_bad++;
                    $display("FAIL %s rx_fix actual=%b expected=%b", e.req, rx_fix[0], e.fix);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state and plain passthrough
        step(0, 0, 0, 0, 1'b0, 0, "R1");
        step(0, 0, 0, 0, 1'b1, 0, "R1");
        // R2 six inverted link pulses hold off, the seventh trips
        lrev(LTHR - 1, "R2");
        lrev(1, "R2");
        idle(2, "R9");
        // R7 normal traffic after detection keeps the flag
        step(1, 0, 1, 0, 1'b1, 0, "R7");
        step(1, 0, 1, 0, 1'b0, 0, "R7");
        idle(3, "R7");
        // R8 clear, with an inverted pulse in the clear cycle ignored
        do_clr("R8");
        lrev(LTHR - 1, "R8");
        step(0, 1, 0, 0, 1'b1, 1, "R8");
        lrev(LTHR - 1, "R8");
        lrev(1, "R8");
        idle(1, "R8");
        do_clr("R8");
        // R3 a normal link pulse restarts the streak; coincident normal wins
        lrev(LTHR - 2, "R3");
        step(1, 0, 0, 0, 1'b0, 0, "R3");
        lrev(LTHR - 1, "R3");
        step(1, 1, 0, 0, 1'b1, 0, "R3");
        lrev(LTHR - 1, "R3");
        lrev(1, "R3");
        idle(1, "R3");
        do_clr("R3");
        // R4 packet path threshold
        erev(PTHR - 1, "R4");
        erev(1, "R4");
        idle(1, "R4");
        do_clr("R4");
        // R5 normal packet ending restarts the streak; coincident normal wins
        erev(PTHR - 1, "R5");
        step(0, 0, 1, 0, 1'b1, 0, "R5");
        erev(PTHR - 1, "R5");
        step(0, 0, 1, 1, 1'b0, 0, "R5");
        erev(PTHR - 1, "R5");
        erev(1, "R5");
        idle(1, "R5");
        do_clr("R5");
        // R6 a normal link pulse leaves the packet streak alone
        erev(PTHR - 1, "R6");
        step(1, 0, 0, 0, 1'b0, 0, "R6");
        erev(1, "R6");
        idle(1, "R6");
        do_clr("R6");
        // R6 a normal packet ending leaves the link streak alone
        lrev(LTHR - 1, "R6");
        step(0, 0, 1, 0, 1'b1, 0, "R6");
        lrev(1, "R6");
        idle(2, "R6");
        // R6 mixed partial streaks do not add up
        do_clr("R6");
        lrev(LTHR - 1, "R6");
        erev(PTHR - 1, "R6");
        idle(2, "R6");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule